// File: doc/BRIEF.md
# SPI Flash Serial Engine

This block is a register-programmed SPI master intended to talk to a serial flash device. Software configures it through a 32-bit memory-mapped register port: a clock divider, clock polarity and phase, a frame format (bit order, direction, frame length, lane protocol field), a chip-select mode, and transmit and receive watermarks with an interrupt enable mask. Each byte software writes into the transmit data register is queued in a transmit FIFO and later sent as one frame on the serial bus.

Frames received on the data-in pin are kept in a receive FIFO only while the direction bit selects receive; with direction set to transmit, incoming bits are thrown away. Software paces transfers by polling the full flag in the transmit data register, the empty flag in the receive data register, and the two watermark pending bits. The chip-select mode lets software keep a device selected across a multi-byte command (opcode, address, data) without gaps. Only single-lane transfer is carried out; the protocol field is stored and read back.

Top module: `spi_flash_engine`

## Requirements
- R1: After reset both FIFOs are empty (receive data bit 31 reads 1, transmit data bit 31 reads 0), every select line sits at its idle level 1, the serial clock is 0, the interrupt output is 0, the divider (offset 0x00) reads 3, the pending register (offset 0x74) reads 0, and the format register (offset 0x40) reads 0x00080000 (length 8, direction receive, MSB first).
- R2: Configuration registers read back what was written: divider 0x00, clock mode 0x04, select index 0x10, select idle levels 0x14, select mode 0x18, format 0x40 (bits 1:0 protocol, bit 2 bit order, bit 3 direction, bits 19:16 frame length), transmit watermark 0x50 and receive watermark 0x54 (bits 15:0), interrupt enable 0x70.
- R3: Clock mode bit 0 sets the idle clock level and bit 1 the phase; each serial clock half-period lasts divider+1 system clocks; with phase 0 data is sampled on the leading edge, with phase 1 on the trailing edge; with format bit 2 = 0 the frame is sent most significant bit first.
- R4: With format bit 2 = 1 a frame is sent and received least significant bit first.
- R5: Writing offset 0x48 queues bits 7:0; reading 0x48 returns the transmit FIFO full flag in bit 31; a write while full is discarded and the queued bytes are sent unchanged.
- R6: Reading offset 0x4C returns the receive empty flag in bit 31 and the oldest byte in bits 7:0, and removes that byte when the FIFO was not empty.
- R7: With format bit 3 = 0 each completed frame is stored in the receive FIFO; with bit 3 = 1 nothing is stored.
- R8: Select mode 0 (auto) drives the selected line active for a frame, keeps it active across back-to-back frames while the transmit FIFO has data, and releases it once the last frame ends with the FIFO empty.
- R9: Select mode 2 (hold) keeps the line active after the frames end until the mode is changed, after which it is released.
- R10: Select mode 3 (off) never drives any select line away from its idle level.
- R11: Pending bit 0 is set while transmit occupancy is below the transmit watermark; pending bit 1 is set while receive occupancy is above the receive watermark; the interrupt output is the OR of pending bits masked by the enable register.
- R12: The select index picks which line is driven; bit i of the idle-level register is that line's inactive level and the active level is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops receive data) |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr |
| irqOut | output | 1 | Masked watermark interrupt |
| sckOut | output | 1 | Serial clock |
| mosiOut | output | 1 | Serial data out |
| misoIn | input | 1 | Serial data in |
| csN | output | NUM_CS | Select lines |

## Verification
The bench builds the engine with two select lines and a FIFO depth of 4, so the transmit FIFO fills after only four queued bytes and the full flag, dropped writes and both watermark comparisons are reached within a few frames. Two select lines make it possible to see that the index steers assertion to line 1 while line 0 stays at its programmed idle level. The serial output is looped back to the input, so every received byte must equal the transmitted one in both bit orders and in clock modes 0 and 3.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int DIV_W   = 12;
  localparam int FRAME_W = 8;
  localparam int LEN_W   = 4;

  localparam logic [7:0] ADDR_DIV    = 8'h00;
  localparam logic [7:0] ADDR_MODE   = 8'h04;
  localparam logic [7:0] ADDR_CSID   = 8'h10;
  localparam logic [7:0] ADDR_CSDEF  = 8'h14;
  localparam logic [7:0] ADDR_CSMODE = 8'h18;
  localparam logic [7:0] ADDR_FMT    = 8'h40;
  localparam logic [7:0] ADDR_TXDATA = 8'h48;
  localparam logic [7:0] ADDR_RXDATA = 8'h4C;
  localparam logic [7:0] ADDR_TXCTL  = 8'h50;
  localparam logic [7:0] ADDR_RXCTL  = 8'h54;
  localparam logic [7:0] ADDR_IE     = 8'h70;
  localparam logic [7:0] ADDR_IP     = 8'h74;

  typedef enum logic [1:0] {
    CS_AUTO = 2'd0,
    CS_RSVD = 2'd1,
    CS_HOLD = 2'd2,
    CS_OFF  = 2'd3
  } csMode_e;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             pol;
    logic             pha;
    logic [1:0]       proto;
    logic             lsbFirst;
    logic             dirTx;
    logic [LEN_W-1:0] frameLen;
    csMode_e          csMode;
  } spiCfg_t;

  typedef struct packed {
    logic               txPush;
    logic [FRAME_W-1:0] txData;
    logic               rxPop;
  } spiStrobe_t;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // Writers must gate on full / empty (R5, R6)
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(push && full));
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(pop && empty));
  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_eng_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CSI_W  = 1,
  parameter int CW     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [7:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  output logic               irqOut,
  input  logic               txFull,
  input  logic [CW-1:0]      txCount,
  input  logic               rxEmpty,
  input  logic [CW-1:0]      rxCount,
  input  logic [FRAME_W-1:0] rxHead,
  output spiCfg_t            cfg,
  output spiStrobe_t         strobe,
  output logic [CSI_W-1:0]   csId,
  output logic [NUM_CS-1:0]  csDef
);
  logic [15:0] txWm, rxWm;
  logic [1:0]  ie, ip;
  logic        unusedWrBits;

  assign unusedWrBits = ^regWrData[31:20];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg.div      <= DIV_W'(3);
      cfg.pol      <= 1'b0;
      cfg.pha      <= 1'b0;
      cfg.proto    <= 2'd0;
      cfg.lsbFirst <= 1'b0;
      cfg.dirTx    <= 1'b0;
      cfg.frameLen <= LEN_W'(FRAME_W);
      cfg.csMode   <= CS_AUTO;
      csId         <= '0;
      csDef        <= '1;
      txWm         <= '0;
      rxWm         <= '0;
      ie           <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        ADDR_DIV:    cfg.div <= regWrData[DIV_W-1:0];
        ADDR_MODE:   {cfg.pha, cfg.pol} <= regWrData[1:0];
        ADDR_CSID:   csId <= regWrData[CSI_W-1:0];
        ADDR_CSDEF:  csDef <= regWrData[NUM_CS-1:0];
        ADDR_CSMODE: cfg.csMode <= csMode_e'(regWrData[1:0]);
        ADDR_FMT: begin
          cfg.proto    <= regWrData[1:0];
          cfg.lsbFirst <= regWrData[2];
          cfg.dirTx    <= regWrData[3];
          cfg.frameLen <= regWrData[19:16];
        end
        ADDR_TXCTL:  txWm <= regWrData[15:0];
        ADDR_RXCTL:  rxWm <= regWrData[15:0];
        ADDR_IE:     ie <= regWrData[1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    ip[0]  = (16'(txCount) < txWm);
    ip[1]  = (16'(rxCount) > rxWm);
    irqOut = |(ip & ie);
  end

  always_comb begin
    strobe.txPush = regWrEn && (regAddr == ADDR_TXDATA) && !txFull;
    strobe.txData = regWrData[FRAME_W-1:0];
    strobe.rxPop  = regRdEn && (regAddr == ADDR_RXDATA) && !rxEmpty;
  end

  always_comb begin
    case (regAddr)
      ADDR_DIV:    regRdData = 32'(cfg.div);
      ADDR_MODE:   regRdData = {30'b0, cfg.pha, cfg.pol};
      ADDR_CSID:   regRdData = 32'(csId);
      ADDR_CSDEF:  regRdData = 32'(csDef);
      ADDR_CSMODE: regRdData = {30'b0, cfg.csMode};
      ADDR_FMT:    regRdData = {12'b0, cfg.frameLen, 12'b0, cfg.dirTx,
                                cfg.lsbFirst, cfg.proto};
      ADDR_TXDATA: regRdData = {txFull, 31'b0};
      ADDR_RXDATA: regRdData = {rxEmpty, 23'b0, rxHead};
      ADDR_TXCTL:  regRdData = {16'b0, txWm};
      ADDR_RXCTL:  regRdData = {16'b0, rxWm};
      ADDR_IE:     regRdData = {30'b0, ie};
      ADDR_IP:     regRdData = {30'b0, ip};
      default:     regRdData = '0;
    endcase
  end

  // A pop request on an empty FIFO must leave the receive count untouched (R6)
  assert_empty_read_keeps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == ADDR_RXDATA && rxEmpty) |=> (rxCount <= 1));
endmodule

// File: rtl/spi_datapath.sv
module spi_datapath
  import spi_eng_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int CSI_W  = 1,
  parameter int DEPTH  = 8,
  parameter int CW     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  spiCfg_t            cfg,
  input  spiStrobe_t         strobe,
  input  logic [CSI_W-1:0]   csId,
  input  logic [NUM_CS-1:0]  csDef,
  input  logic               misoIn,
  output logic               sckOut,
  output logic               mosiOut,
  output logic [NUM_CS-1:0]  csN,
  output logic               txFull,
  output logic [CW-1:0]      txCount,
  output logic               rxEmpty,
  output logic [CW-1:0]      rxCount,
  output logic [FRAME_W-1:0] rxHead
);
  localparam logic [LEN_W-1:0] FRAME_LEN = LEN_W'(FRAME_W);

  logic               txEmpty, rxFull;
  logic [FRAME_W-1:0] txHead, txShift, rxShift, rxFinal;
  logic               busy, halfB, csActive;
  logic [DIV_W-1:0]   divCnt;
  logic [LEN_W-1:0]   bitCnt, lenEff;
  logic               txPop, halfEnd, lastBit, frameDone, rxPush;

  spi_fifo #(.WIDTH(FRAME_W), .DEPTH(DEPTH), .CW(CW)) u_txFifo (
    .clk(clk), .rstN(rstN),
    .push(strobe.txPush), .pushData(strobe.txData),
    .pop(txPop), .headData(txHead),
    .count(txCount), .full(txFull), .empty(txEmpty)
  );

  spi_fifo #(.WIDTH(FRAME_W), .DEPTH(DEPTH), .CW(CW)) u_rxFifo (
    .clk(clk), .rstN(rstN),
    .push(rxPush), .pushData(rxFinal),
    .pop(strobe.rxPop), .headData(rxHead),
    .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  always_comb begin
    lenEff    = (cfg.frameLen == '0 || cfg.frameLen > FRAME_LEN) ? FRAME_LEN : cfg.frameLen;
    txPop     = !busy && !txEmpty;
    halfEnd   = busy && (divCnt == cfg.div);
    lastBit   = (bitCnt == lenEff - 1'b1);
    frameDone = halfEnd && halfB && lastBit;
    rxPush    = frameDone && !cfg.dirTx && !rxFull;
    rxFinal   = cfg.lsbFirst ? (rxShift >> (FRAME_LEN - lenEff)) : rxShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      halfB    <= 1'b0;
      divCnt   <= '0;
      bitCnt   <= '0;
      txShift  <= '0;
      rxShift  <= '0;
      csActive <= 1'b0;
    end else if (txPop) begin
      busy    <= 1'b1;
      halfB   <= 1'b0;
      divCnt  <= '0;
      bitCnt  <= '0;
      txShift <= cfg.lsbFirst ? txHead : (txHead << (FRAME_LEN - lenEff));
      rxShift <= '0;
      if (cfg.csMode != CS_OFF) csActive <= 1'b1;
    end else if (busy) begin
      if (!halfEnd) begin
        divCnt <= divCnt + 1'b1;
      end else begin
        divCnt <= '0;
        if (!halfB) begin
          halfB   <= 1'b1;
          rxShift <= cfg.lsbFirst ? {misoIn, rxShift[FRAME_W-1:1]}
                                  : {rxShift[FRAME_W-2:0], misoIn};
        end else begin
          halfB <= 1'b0;
          if (lastBit) begin
            busy <= 1'b0;
          end else begin
            bitCnt  <= bitCnt + 1'b1;
            txShift <= cfg.lsbFirst ? (txShift >> 1) : (txShift << 1);
          end
        end
      end
    end else if (cfg.csMode != CS_HOLD) begin
      csActive <= 1'b0;
    end
  end

  assign sckOut  = busy ? (cfg.pol ^ (cfg.pha ? ~halfB : halfB)) : cfg.pol;
  assign mosiOut = busy & (cfg.lsbFirst ? txShift[0] : txShift[FRAME_W-1]);

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign csN[i] = (csActive && cfg.csMode != CS_OFF && csId == CSI_W'(i))
                      ? ~csDef[i] : csDef[i];
    end
  endgenerate

  assert_half_period_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && (sckOut != $past(sckOut))) |-> ($past(divCnt) == $past(cfg.div)));
  assert_tx_dir_no_store_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.dirTx && !strobe.rxPop) |=> (rxCount <= $past(rxCount)));
  assert_select_on_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && cfg.csMode != CS_OFF) |=> csActive);
  assert_hold_keeps_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.csMode == CS_HOLD && $past(cfg.csMode) == CS_HOLD && $past(csActive)) |-> csActive);
endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
  import spi_eng_pkg::*;
#(
  parameter int NUM_CS     = 2,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqOut,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  output logic [NUM_CS-1:0] csN
);
  localparam int CSI_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int CW    = $clog2(FIFO_DEPTH + 1);

  spiCfg_t            cfg;
  spiStrobe_t         strobe;
  logic [CSI_W-1:0]   csId;
  logic [NUM_CS-1:0]  csDef;
  logic               txFull, rxEmpty;
  logic [CW-1:0]      txCount, rxCount;
  logic [FRAME_W-1:0] rxHead;

  spi_ctrl #(.NUM_CS(NUM_CS), .CSI_W(CSI_W), .CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut),
    .txFull(txFull), .txCount(txCount), .rxEmpty(rxEmpty),
    .rxCount(rxCount), .rxHead(rxHead),
    .cfg(cfg), .strobe(strobe), .csId(csId), .csDef(csDef)
  );

  spi_datapath #(.NUM_CS(NUM_CS), .CSI_W(CSI_W), .DEPTH(FIFO_DEPTH), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN),
    .cfg(cfg), .strobe(strobe), .csId(csId), .csDef(csDef),
    .misoIn(misoIn), .sckOut(sckOut), .mosiOut(mosiOut), .csN(csN),
    .txFull(txFull), .txCount(txCount), .rxEmpty(rxEmpty),
    .rxCount(rxCount), .rxHead(rxHead)
  );
endmodule

// File: tb/spi_flash_engine_tb.sv
module spi_flash_engine_tb;
  localparam int NCS   = 2;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWrData = 32'h0;
  logic [31:0] regRdData;
  logic        irqOut, sckOut, mosiOut, misoIn;
  logic [NCS-1:0] csN;

  always #5 clk = ~clk;
  assign misoIn = mosiOut;

  spi_flash_engine #(.NUM_CS(NCS), .FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut), .sckOut(sckOut), .mosiOut(mosiOut), .misoIn(misoIn),
    .csN(csN)
  );

  int nRun = 0, nFail = 0;
  bit done = 0;
  logic [7:0] expTx[$];
  logic [7:0] expRx[$];

  bit curPol = 0, curPha = 0, curLsb = 0;
  int curDiv = 3;
  bit monMute = 1;
  logic prevSck = 1'b0, prevCs0 = 1'b1;
  int cyc = 0, leadCyc = 0, bitIdx = 0, csRise = 0;
  bit firstBit = 0;
  logic [7:0] acc = 8'h00;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); #1 regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(posedge clk); #1 regRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic waitFrames(input int n);
    idle(n * (16 * (curDiv + 1) + 8));
  endtask

  // driver: queue a byte and record what the bus and the receive FIFO must show
  task automatic send(input logic [7:0] b, input bit keep);
    wr(8'h48, {24'b0, b});
    expTx.push_back(b);
    if (keep) expRx.push_back(b);
  endtask

  task automatic readRx(input string req);
    logic [31:0] d;
    rd(8'h4C, d);
    if (expRx.size() > 0) check(req, d, {24'b0, expRx.pop_front()});
    else check(req, {31'b0, d[31]}, 32'd1);
  endtask

  task automatic setMode(input bit pol, input bit pha);
    monMute = 1;
    wr(8'h04, {30'b0, pha, pol});
    curPol = pol; curPha = pha;
    idle(2);
    monMute = 0;
  endtask

  // monitor: rebuild frames from the bus and compare with the driver queue
  always @(negedge clk) begin
    cyc++;
    if (rstN && prevCs0 === 1'b0 && csN[0] === 1'b1) csRise++;
    prevCs0 = csN[0];
    if (monMute || !rstN) begin
      prevSck = sckOut;
      bitIdx  = 0;
    end else if (sckOut !== prevSck) begin
      bit lead;
      lead = (prevSck === curPol);
      if (lead) begin
        leadCyc  = cyc;
        firstBit = (bitIdx == 0);
      end else if (firstBit) begin
        check("R3 half period", cyc - leadCyc, curDiv + 1);
        firstBit = 0;
      end
      if (lead != curPha) begin
        acc = curLsb ? {mosiOut, acc[7:1]} : {acc[6:0], mosiOut};
        bitIdx++;
        if (bitIdx == 8) begin
          bitIdx = 0;
          if (expTx.size() == 0) check("R5 unexpected frame", {24'b0, acc}, 32'hFFFF_FFFF);
          else check("R3 R4 frame bits", {24'b0, acc}, {24'b0, expTx.pop_front()});
        end
      end
      prevSck = sckOut;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int r0;
    idle(5);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    rd(8'h4C, d); check("R1 rx empty", {31'b0, d[31]}, 1);
    rd(8'h48, d); check("R1 tx not full", {31'b0, d[31]}, 0);
    check("R1 select idle", {30'b0, csN}, 32'd3);
    check("R1 sck idle", {31'b0, sckOut}, 0);
    check("R1 irq", {31'b0, irqOut}, 0);
    rd(8'h40, d); check("R1 format", d, 32'h0008_0000);
    rd(8'h74, d); check("R1 pending", d, 0);
    rd(8'h00, d); check("R1 divider", d, 3);
    monMute = 0;

    // R2 readback
    wr(8'h00, 1); curDiv = 1;
    rd(8'h00, d); check("R2 divider", d, 1);
    wr(8'h54, 16'h0123); rd(8'h54, d); check("R2 rx watermark", d, 32'h0123);
    wr(8'h40, 32'h0008_0002); rd(8'h40, d); check("R2 format", d, 32'h0008_0002);
    wr(8'h40, 32'h0008_0000);
    wr(8'h70, 2); rd(8'h70, d); check("R2 enable", d, 2);
    wr(8'h70, 0);
    wr(8'h10, 1); rd(8'h10, d); check("R2 select index", d, 1);
    wr(8'h10, 0);

    // R3 R8 R7 R6: mode 0, MSB first, back-to-back frames in auto select
    r0 = csRise;
    send(8'hA5, 1);
    send(8'h3C, 1);
    idle(20);
    check("R8 select active", {31'b0, csN[0]}, 0);
    waitFrames(2);
    check("R8 one release", csRise, r0 + 1);
    check("R8 released", {31'b0, csN[0]}, 1);
    readRx("R6 R7 first byte");
    readRx("R6 R7 second byte");
    readRx("R6 empty after pops");

    // R7 transmit direction stores nothing
    wr(8'h40, 32'h0008_0008);
    send(8'h5A, 0);
    waitFrames(1);
    readRx("R7 transmit direction");

    // R4 LSB first
    wr(8'h40, 32'h0008_0004); curLsb = 1;
    send(8'h81, 1);
    send(8'h36, 1);
    waitFrames(2);
    readRx("R4 lsb byte a");
    readRx("R4 lsb byte b");
    wr(8'h40, 32'h0008_0000); curLsb = 0;

    // R3 mode 3
    setMode(1, 1);
    wr(8'h00, 2); curDiv = 2;
    check("R3 idle high", {31'b0, sckOut}, 1);
    send(8'hC3, 1);
    waitFrames(1);
    readRx("R3 mode3 byte");
    setMode(0, 0);

    // R9 hold
    wr(8'h18, 2);
    send(8'h11, 1);
    waitFrames(1);
    idle(10);
    check("R9 held after frame", {31'b0, csN[0]}, 0);
    wr(8'h18, 0);
    idle(3);
    check("R9 released on change", {31'b0, csN[0]}, 1);
    readRx("R9 byte");

    // R10 off
    wr(8'h18, 3);
    send(8'h22, 1);
    idle(10);
    check("R10 no select", {30'b0, csN}, 32'd3);
    waitFrames(1);
    readRx("R10 byte");
    wr(8'h18, 0);

    // R12 index and idle levels
    wr(8'h14, 2'b10);
    wr(8'h10, 1);
    send(8'h42, 1);
    idle(10);
    check("R12 line1 active", {30'b0, csN}, 32'd0);
    waitFrames(1);
    check("R12 idle levels", {30'b0, csN}, 32'd2);
    readRx("R12 byte");
    wr(8'h14, 2'b11);
    wr(8'h10, 0);

    // R5 R11 full FIFO, dropped write, transmit watermark
    wr(8'h40, 32'h0008_0008);
    wr(8'h00, 20); curDiv = 20;
    wr(8'h50, 2);
    wr(8'h70, 1);
    send(8'h10, 0);
    idle(4);
    send(8'h11, 0); send(8'h12, 0); send(8'h13, 0); send(8'h14, 0);
    rd(8'h48, d); check("R5 full flag", {31'b0, d[31]}, 1);
    rd(8'h74, d); check("R11 tx above watermark", d, 0);
    check("R11 irq low", {31'b0, irqOut}, 0);
    wr(8'h48, 8'h15);
    waitFrames(6);
    rd(8'h48, d); check("R5 not full after drain", {31'b0, d[31]}, 0);
    check("R5 all queued sent", expTx.size(), 0);
    rd(8'h74, d); check("R11 tx below watermark", d, 1);
    check("R11 irq high", {31'b0, irqOut}, 1);

    // R11 receive watermark
    wr(8'h00, 1); curDiv = 1;
    wr(8'h40, 32'h0008_0000);
    wr(8'h54, 1);
    wr(8'h70, 2);
    send(8'h66, 1);
    send(8'h77, 1);
    waitFrames(2);
    rd(8'h74, d); check("R11 rx above watermark", d, 3);
    check("R11 irq rx", {31'b0, irqOut}, 1);
    readRx("R11 byte a");
    rd(8'h74, d); check("R11 rx at watermark", d, 1);
    check("R11 irq rx low", {31'b0, irqOut}, 0);
    readRx("R11 byte b");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule